// File: doc/BRIEF.md
# Coprocessor Handshake Sequencer

This block runs one coprocessor instruction at a time and holds the whole conversation with an external coprocessor. An instruction can move a register to the coprocessor, read a register back, start an internal data operation, or load or store a run of words. The sequencer sends a phase code on every request cycle. The coprocessor answers in that same cycle with done, busy, cannot or increment. When the coprocessor is busy the sequencer waits one idle cycle and then asks again. During that idle cycle it checks for pending interrupts, and if one is pending it abandons the instruction.

For memory transfers the sequencer drives word addresses to a simple memory port. The first address comes with the instruction. After that the coprocessor sets the length of the burst by answering increment after each word. An address that is out of range, or a store into the vector area, sets an internal abort flag before the handshake starts. A bus abort reported by memory is remembered until the end of the burst. Each instruction ends with a one-cycle completion strobe that carries an end code, the interrupt source when the instruction was abandoned, and the returned data for a register read.

Top module: `cop_handshake_seq`

## Requirements
- R1: After reset `ready_o` is 1 and `cp_req_o`, `mem_req_o` and `done_o` are 0.
- R2: `start_i` is accepted only while `ready_o` is 1, and a start raised while an instruction is running has no effect. Operation codes on `op_i`: 0 write to coprocessor, 1 read from coprocessor, 2 data operation, 3 load, 4 store. In the cycle after acceptance the block issues a request with phase FIRST (code 0).
- R3: A BUSY reply (code 1) to a FIRST or BUSY phase is followed by exactly one cycle with no request, and then by a new request with phase BUSY (code 1). `wait_cycles_o` counts these idle cycles and stops at 2^CW-1.
- R4: If an interrupt is pending in an idle wait cycle, the block issues one request with phase INTERRUPT (code 2) and then completes with end code 4. `intr_src_o` names the winner by priority: reset request (1) first, then fast interrupt (2) when `fiq_dis_i` is low, then normal interrupt (3) when `irq_dis_i` is low. Without a BUSY reply, interrupts are never checked.
- R5: A CANT reply (code 2) to operation 0, 1 or 2 ends with end code 1 (undefined). For a read, `rdata_o` then holds `flags_i` in its top 4 bits and zeros below.
- R6: A CANT reply to a load or store ends with end code 2 (coprocessor abort), and no memory request is made.
- R7: A load or store that is accepted issues one TRANSFER phase (code 3) and then DATA phases (code 4), moving one word per DATA phase. An INC reply (code 3) moves the next word at an address DW/8 higher, and a DONE reply (code 0) ends the burst. A load forwards `mem_rdata_i` on `cp_wdata_o`. A store writes `cp_rdata_i` to memory.
- R8: If any start-address bit at or above ADDR_OK_BITS is set, or a store starts below VEC_LIMIT, the handshake still runs but no memory request is made, and the instruction ends with end code 3 (data abort).
- R9: If `mem_abort_i` is high during any word of a burst, the remaining words are still moved and the instruction ends with end code 3.
- R10: When a read is accepted, one DATA phase captures `cp_rdata_i` and is followed by one idle cycle. Completion then follows with that value held on `rdata_o`.
- R11: `done_o` is high for exactly one cycle, carries `end_code_o` (0 on success), and is followed by `ready_o` high. Counting cycles from acceptance with B busy replies and W words, it rises after 2+2B cycles for operations 0 and 2 and for CANT, after 4+2B for a read, after 3+2B+W for a memory burst, and after 4 for an abandoned instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start_i | input | 1 | Start an instruction |
| op_i | input | 3 | Operation code |
| addr_i | input | AW | Start address for load/store |
| src_data_i | input | DW | Value sent to the coprocessor for a register write |
| flags_i | input | 4 | Condition flags returned on a failed read |
| ready_o | output | 1 | Idle, able to accept a start |
| cp_req_o | output | 1 | Request to the coprocessor this cycle |
| cp_phase_o | output | 3 | Phase code of the request |
| cp_wdata_o | output | DW | Data to the coprocessor |
| cp_reply_i | input | 2 | Same-cycle reply: 0 done, 1 busy, 2 cant, 3 inc |
| cp_rdata_i | input | DW | Data from the coprocessor |
| mem_req_o | output | 1 | Memory word access |
| mem_we_o | output | 1 | Access is a write |
| mem_addr_o | output | AW | Memory byte address |
| mem_wdata_o | output | DW | Memory write data |
| mem_rdata_i | input | DW | Memory read data, same cycle |
| mem_abort_i | input | 1 | Bus abort for the current access |
| reset_req_i | input | 1 | Pending reset request |
| fiq_i | input | 1 | Fast interrupt request |
| fiq_dis_i | input | 1 | Fast interrupt disable |
| irq_i | input | 1 | Normal interrupt request |
| irq_dis_i | input | 1 | Normal interrupt disable |
| done_o | output | 1 | One-cycle completion strobe |
| end_code_o | output | 3 | 0 ok, 1 undefined, 2 coprocessor abort, 3 data abort, 4 interrupted |
| intr_src_o | output | 2 | Interrupt that abandoned the instruction |
| rdata_o | output | DW | Value returned by a read |
| wait_cycles_o | output | CW | Idle wait cycles of the current instruction |

## Verification
The bench builds the block with AW=16, CW=3, ADDR_OK_BITS=12 and VEC_LIMIT=32. With these values a run of nine busy replies saturates the wait counter at 7. An out-of-range address only needs bit 12 set. The vector area covers the first eight words of a small memory model, so both internal-abort causes and counter saturation are reached with short, cheap instructions. The default data width of 32 keeps the word step at 4 bytes.

// File: rtl/cphs_pkg.sv
package cphs_pkg;

   typedef enum logic [2:0] {
      OP_WR_CP = 3'd0,
      OP_RD_CP = 3'd1,
      OP_CALC  = 3'd2,
      OP_LOAD  = 3'd3,
      OP_STORE = 3'd4
   } cp_op_e;

   typedef enum logic [2:0] {
      PH_FIRST = 3'd0,
      PH_BUSY  = 3'd1,
      PH_INTR  = 3'd2,
      PH_XFER  = 3'd3,
      PH_DATA  = 3'd4
   } phase_e;

   typedef enum logic [1:0] {
      RP_DONE = 2'd0,
      RP_BUSY = 2'd1,
      RP_CANT = 2'd2,
      RP_INC  = 2'd3
   } reply_e;

   typedef enum logic [2:0] {
      END_OK    = 3'd0,
      END_UNDEF = 3'd1,
      END_CPABT = 3'd2,
      END_DABT  = 3'd3,
      END_INTR  = 3'd4
   } end_e;

   typedef enum logic [1:0] {
      SRC_NONE = 2'd0,
      SRC_RST  = 2'd1,
      SRC_FAST = 2'd2,
      SRC_NORM = 2'd3
   } isrc_e;

   typedef enum logic [3:0] {
      ST_IDLE, ST_ASK, ST_WAIT, ST_INTR, ST_XFER,
      ST_DATA, ST_RDDATA, ST_GAP, ST_DONE
   } seq_state_e;

endpackage

// File: rtl/cphs_irq_prio.sv
module cphs_irq_prio
   import cphs_pkg::*;
#(
   parameter bit HAS_FAST = 1'b1
) (
   input  logic  reset_req_i,
   input  logic  fiq_i,
   input  logic  fiq_dis_i,
   input  logic  irq_i,
   input  logic  irq_dis_i,
   output logic  pend_o,
   output isrc_e src_o
);
   logic fast_live;
   logic norm_live;

   generate
      if (HAS_FAST) begin : g_fast
         assign fast_live = fiq_i && !fiq_dis_i;
      end else begin : g_nofast
         assign fast_live = 1'b0 & fiq_i & fiq_dis_i;
      end
   endgenerate

   assign norm_live = irq_i && !irq_dis_i;

   always_comb begin
      if (reset_req_i)    src_o = SRC_RST;
      else if (fast_live) src_o = SRC_FAST;
      else if (norm_live) src_o = SRC_NORM;
      else                src_o = SRC_NONE;
   end

   assign pend_o = (src_o != SRC_NONE);
endmodule

// File: rtl/cphs_addr_unit.sv
module cphs_addr_unit #(
   parameter int AW           = 32,
   parameter int STEP         = 4,
   parameter int ADDR_OK_BITS = 26,
   parameter int VEC_LIMIT    = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          load_i,
   input  logic          store_i,
   input  logic          adv_i,
   input  logic [AW-1:0] addr_i,
   output logic [AW-1:0] addr_o,
   output logic          bad_o
);
   logic range_exc;
   logic vec_hit;

   generate
      if (ADDR_OK_BITS >= AW) begin : g_norange
         assign range_exc = 1'b0;
      end else begin : g_range
         assign range_exc = |addr_i[AW-1:ADDR_OK_BITS];
      end
   endgenerate

   generate
      if (VEC_LIMIT <= 0) begin : g_novec
         assign vec_hit = 1'b0 & store_i;
      end else begin : g_vec
         assign vec_hit = store_i && (addr_i < AW'(VEC_LIMIT));
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         addr_o <= '0;
         bad_o  <= 1'b0;
      end else if (load_i) begin
         addr_o <= addr_i;
         bad_o  <= range_exc || vec_hit;
      end else if (adv_i) begin
         addr_o <= addr_o + AW'(STEP);
      end
   end
endmodule

// File: rtl/cphs_wait_ctr.sv
module cphs_wait_ctr #(
   parameter int CW = 8
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          clr_i,
   input  logic          inc_i,
   output logic [CW-1:0] count_o
);
   localparam logic [CW-1:0] CNT_MAX = '1;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                            count_o <= '0;
      else if (clr_i)                        count_o <= '0;
      else if (inc_i && count_o != CNT_MAX)  count_o <= count_o + 1'b1;
   end
endmodule

// File: rtl/cop_handshake_seq.sv
module cop_handshake_seq
   import cphs_pkg::*;
#(
   parameter int DW           = 32,
   parameter int AW           = 32,
   parameter int CW           = 8,
   parameter int ADDR_OK_BITS = 26,
   parameter int VEC_LIMIT    = 32,
   parameter bit HAS_FAST     = 1'b1
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_i,
   input  logic [2:0]    op_i,
   input  logic [AW-1:0] addr_i,
   input  logic [DW-1:0] src_data_i,
   input  logic [3:0]    flags_i,
   output logic          ready_o,
   output logic          cp_req_o,
   output logic [2:0]    cp_phase_o,
   output logic [DW-1:0] cp_wdata_o,
   input  logic [1:0]    cp_reply_i,
   input  logic [DW-1:0] cp_rdata_i,
   output logic          mem_req_o,
   output logic          mem_we_o,
   output logic [AW-1:0] mem_addr_o,
   output logic [DW-1:0] mem_wdata_o,
   input  logic [DW-1:0] mem_rdata_i,
   input  logic          mem_abort_i,
   input  logic          reset_req_i,
   input  logic          fiq_i,
   input  logic          fiq_dis_i,
   input  logic          irq_i,
   input  logic          irq_dis_i,
   output logic          done_o,
   output logic [2:0]    end_code_o,
   output logic [1:0]    intr_src_o,
   output logic [DW-1:0] rdata_o,
   output logic [CW-1:0] wait_cycles_o
);
   localparam int STEP   = DW / 8;
   localparam int FLAG_W = 4;

   generate
      if (DW % 8 != 0 || DW < 8) begin : g_bad_dw
         $error("cop_handshake_seq: DW must be a non-zero multiple of 8");
      end
      if (DW <= FLAG_W) begin : g_bad_flags
         $error("cop_handshake_seq: DW too small to carry the flags");
      end
      if (CW < 1) begin : g_bad_cw
         $error("cop_handshake_seq: CW must be at least 1");
      end
      if (ADDR_OK_BITS < 1) begin : g_bad_ok
         $error("cop_handshake_seq: ADDR_OK_BITS must be positive");
      end
   endgenerate

   seq_state_e   state;
   cp_op_e       op_q;
   logic [DW-1:0] src_q;
   logic          first_q;
   logic          mab_q;
   end_e          end_q;
   isrc_e         isrc_q;
   logic [DW-1:0] rdata_q;

   reply_e rep;
   logic   is_mem;
   logic   accept;
   logic   addr_bad;
   logic   pend;
   isrc_e  pend_src;
   logic   adv;

   assign rep    = reply_e'(cp_reply_i);
   assign is_mem = (op_q == OP_LOAD) || (op_q == OP_STORE);
   assign accept = (state == ST_IDLE) && start_i;
   assign adv    = (state == ST_DATA) && (rep == RP_INC);

   cphs_irq_prio #(.HAS_FAST(HAS_FAST)) u_prio (
      .reset_req_i (reset_req_i),
      .fiq_i       (fiq_i),
      .fiq_dis_i   (fiq_dis_i),
      .irq_i       (irq_i),
      .irq_dis_i   (irq_dis_i),
      .pend_o      (pend),
      .src_o       (pend_src)
   );

   cphs_addr_unit #(
      .AW(AW), .STEP(STEP), .ADDR_OK_BITS(ADDR_OK_BITS), .VEC_LIMIT(VEC_LIMIT)
   ) u_addr (
      .clk     (clk),
      .rst_n   (rst_n),
      .load_i  (accept),
      .store_i (op_i == 3'(OP_STORE)),
      .adv_i   (adv),
      .addr_i  (addr_i),
      .addr_o  (mem_addr_o),
      .bad_o   (addr_bad)
   );

   cphs_wait_ctr #(.CW(CW)) u_wait (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr_i   (accept),
      .inc_i   (state == ST_WAIT),
      .count_o (wait_cycles_o)
   );

   // Request side: every output is a function of registered state only,
   // so the coprocessor sees a stable phase for the whole cycle.
   always_comb begin
      cp_req_o   = 1'b0;
      cp_phase_o = 3'(PH_FIRST);
      unique case (state)
         ST_ASK: begin
            cp_req_o   = 1'b1;
            cp_phase_o = first_q ? 3'(PH_FIRST) : 3'(PH_BUSY);
         end
         ST_INTR: begin
            cp_req_o   = 1'b1;
            cp_phase_o = 3'(PH_INTR);
         end
         ST_XFER: begin
            cp_req_o   = 1'b1;
            cp_phase_o = 3'(PH_XFER);
         end
         ST_DATA, ST_RDDATA: begin
            cp_req_o   = 1'b1;
            cp_phase_o = 3'(PH_DATA);
         end
         default: ;
      endcase
   end

   assign mem_req_o   = (state == ST_DATA) && is_mem && !addr_bad;
   assign mem_we_o    = mem_req_o && (op_q == OP_STORE);
   assign mem_wdata_o = cp_rdata_i;
   assign cp_wdata_o  = ((state == ST_DATA) && (op_q == OP_LOAD)) ? mem_rdata_i : src_q;

   assign ready_o    = (state == ST_IDLE);
   assign done_o     = (state == ST_DONE);
   assign end_code_o = 3'(end_q);
   assign intr_src_o = 2'(isrc_q);
   assign rdata_o    = rdata_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state   <= ST_IDLE;
         op_q    <= OP_WR_CP;
         src_q   <= '0;
         first_q <= 1'b0;
         mab_q   <= 1'b0;
         end_q   <= END_OK;
         isrc_q  <= SRC_NONE;
         rdata_q <= '0;
      end else begin
         unique case (state)
            ST_IDLE: if (start_i) begin
               state   <= ST_ASK;
               op_q    <= cp_op_e'(op_i);
               src_q   <= src_data_i;
               first_q <= 1'b1;
               mab_q   <= 1'b0;
               isrc_q  <= SRC_NONE;
            end
            ST_ASK: begin
               unique case (rep)
                  RP_BUSY: begin
                     state   <= ST_WAIT;
                     first_q <= 1'b0;
                  end
                  RP_CANT: begin
                     state <= ST_DONE;
                     end_q <= is_mem ? END_CPABT : END_UNDEF;
                     if (op_q == OP_RD_CP)
                        rdata_q <= {flags_i, {(DW-FLAG_W){1'b0}}};
                  end
                  default: begin
                     if (is_mem)
                        state <= ST_XFER;
                     else if (op_q == OP_RD_CP)
                        state <= ST_RDDATA;
                     else begin
                        state <= ST_DONE;
                        end_q <= END_OK;
                     end
                  end
               endcase
            end
            ST_WAIT: begin
               if (pend) begin
                  state  <= ST_INTR;
                  isrc_q <= pend_src;
               end else begin
                  state <= ST_ASK;
               end
            end
            ST_INTR: begin
               state <= ST_DONE;
               end_q <= END_INTR;
            end
            ST_XFER: state <= ST_DATA;
            ST_DATA: begin
               if (mem_req_o && mem_abort_i) mab_q <= 1'b1;
               if (rep != RP_INC) begin
                  state <= ST_DONE;
                  end_q <= (addr_bad || mab_q || (mem_req_o && mem_abort_i))
                           ? END_DABT : END_OK;
               end
            end
            ST_RDDATA: begin
               rdata_q <= cp_rdata_i;
               state   <= ST_GAP;
            end
            ST_GAP: begin
               state <= ST_DONE;
               end_q <= END_OK;
            end
            ST_DONE: state <= ST_IDLE;
            default: state <= ST_IDLE;
         endcase
      end
   end
endmodule

// File: rtl/cphs_checker.sv
module cphs_checker
   import cphs_pkg::*;
#(
   parameter int AW   = 32,
   parameter int STEP = 4
) (
   input logic          clk,
   input logic          rst_n,
   input logic          start_i,
   input logic          ready_o,
   input logic          cp_req_o,
   input logic [2:0]    cp_phase_o,
   input logic [1:0]    cp_reply_i,
   input logic          mem_req_o,
   input logic [AW-1:0] mem_addr_o,
   input logic          done_o,
   input logic [2:0]    end_code_o
);
   logic ask_busy;
   assign ask_busy = cp_req_o && cp_reply_i == 2'(RP_BUSY) &&
                     (cp_phase_o == 3'(PH_FIRST) || cp_phase_o == 3'(PH_BUSY));

   a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
      ready_o |-> (!cp_req_o && !mem_req_o && !done_o));

   a_r2_first_phase: assert property (@(posedge clk) disable iff (!rst_n)
      (ready_o && start_i) |=> (cp_req_o && cp_phase_o == 3'(PH_FIRST)));

   a_r3_idle_after_busy: assert property (@(posedge clk) disable iff (!rst_n)
      ask_busy |=> !cp_req_o);

   a_r3_reissue: assert property (@(posedge clk) disable iff (!rst_n)
      ask_busy |=> ##1 (cp_req_o &&
         (cp_phase_o == 3'(PH_BUSY) || cp_phase_o == 3'(PH_INTR))));

   a_r4_intr_ends: assert property (@(posedge clk) disable iff (!rst_n)
      (cp_req_o && cp_phase_o == 3'(PH_INTR)) |=>
         (done_o && end_code_o == 3'(END_INTR)));

   a_r7_step: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req_o && cp_reply_i == 2'(RP_INC)) |=>
         (mem_req_o && mem_addr_o == $past(mem_addr_o) + AW'(STEP)));

   a_r7_mem_in_data: assert property (@(posedge clk) disable iff (!rst_n)
      mem_req_o |-> (cp_req_o && cp_phase_o == 3'(PH_DATA)));

   a_r11_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      done_o |=> (!done_o && ready_o));
endmodule

bind cop_handshake_seq cphs_checker #(.AW(AW), .STEP(STEP)) u_cphs_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .start_i    (start_i),
   .ready_o    (ready_o),
   .cp_req_o   (cp_req_o),
   .cp_phase_o (cp_phase_o),
   .cp_reply_i (cp_reply_i),
   .mem_req_o  (mem_req_o),
   .mem_addr_o (mem_addr_o),
   .done_o     (done_o),
   .end_code_o (end_code_o)
);

// File: tb/cop_handshake_seq_bench.sv
module cop_handshake_seq_bench;
   import cphs_pkg::*;

   localparam int CLK_PERIOD = 10;
   localparam int DW = 32;
   localparam int AW = 16;
   localparam int CW = 3;
   localparam int OKB = 12;
   localparam int VEC = 32;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          start_i = 1'b0;
   logic [2:0]    op_i = '0;
   logic [AW-1:0] addr_i = '0;
   logic [DW-1:0] src_data_i = '0;
   logic [3:0]    flags_i = '0;
   logic          ready_o, cp_req_o, mem_req_o, mem_we_o, done_o;
   logic [2:0]    cp_phase_o, end_code_o;
   logic [DW-1:0] cp_wdata_o, mem_wdata_o, rdata_o;
   logic [1:0]    cp_reply_i = '0;
   logic [DW-1:0] cp_rdata_i = '0;
   logic [AW-1:0] mem_addr_o;
   logic [DW-1:0] mem_rdata_i = '0;
   logic          mem_abort_i = 1'b0;
   logic          reset_req_i = 1'b0, fiq_i = 1'b0, fiq_dis_i = 1'b0;
   logic          irq_i = 1'b0, irq_dis_i = 1'b0;
   logic [1:0]    intr_src_o;
   logic [CW-1:0] wait_cycles_o;

   int n_chk = 0;
   int n_fail = 0;
   int inst_id = 0;
   logic [DW-1:0] mem [64];

   always #(CLK_PERIOD/2) clk = ~clk;

   cop_handshake_seq #(
      .DW(DW), .AW(AW), .CW(CW), .ADDR_OK_BITS(OKB), .VEC_LIMIT(VEC)
   ) u_cop_handshake_seq (
      .clk(clk), .rst_n(rst_n), .start_i(start_i), .op_i(op_i),
      .addr_i(addr_i), .src_data_i(src_data_i), .flags_i(flags_i),
      .ready_o(ready_o), .cp_req_o(cp_req_o), .cp_phase_o(cp_phase_o),
      .cp_wdata_o(cp_wdata_o), .cp_reply_i(cp_reply_i), .cp_rdata_i(cp_rdata_i),
      .mem_req_o(mem_req_o), .mem_we_o(mem_we_o), .mem_addr_o(mem_addr_o),
      .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i),
      .mem_abort_i(mem_abort_i), .reset_req_i(reset_req_i), .fiq_i(fiq_i),
      .fiq_dis_i(fiq_dis_i), .irq_i(irq_i), .irq_dis_i(irq_dis_i),
      .done_o(done_o), .end_code_o(end_code_o), .intr_src_o(intr_src_o),
      .rdata_o(rdata_o), .wait_cycles_o(wait_cycles_o)
   );

   task automatic chk(input string req, input string what,
                      input longint act, input longint exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
      end
   endtask

   // lines = {reset_req, fiq, fiq_dis, irq, irq_dis}
   function automatic int prio(input logic [4:0] lines);
      if (lines[4])                 return 1;
      else if (lines[3] && !lines[2]) return 2;
      else if (lines[1] && !lines[0]) return 3;
      else                          return 0;
   endfunction

   function automatic logic [DW-1:0] pat(input int id, input int k);
      return 32'h5A00_0000 | DW'(id << 8) | DW'(k);
   endfunction

   task automatic run_instr(input int op, input logic [AW-1:0] addr,
                            input int nbusy, input bit cant, input int ninc,
                            input int abort_k, input logic [4:0] lines,
                            input bit poke, input string req);
      int busy_left = nbusy;
      int inc_left = ninc;
      int k = 0, cyc = 0, macc = 0, aerr = 0, derr = 0;
      logic [DW-1:0] rd_val = $urandom;
      logic [3:0] fl = 4'($urandom);
      int e_code, e_cyc, e_wait, e_src, e_macc, words;
      bit is_mem, bad, hit;
      int got_code, got_src;
      logic [DW-1:0] got_rdata;
      logic [CW-1:0] got_wait;
      inst_id++;
      {reset_req_i, fiq_i, fiq_dis_i, irq_i, irq_dis_i} = lines;
      flags_i = fl;
      src_data_i = $urandom;
      @(negedge clk);
      chk("R2", "ready before start", longint'(ready_o), 1);
      start_i = 1'b1; op_i = 3'(op); addr_i = addr;
      @(negedge clk);
      start_i = 1'b0;
      forever begin
         cyc++;
         cp_reply_i = 2'(RP_DONE);
         mem_abort_i = 1'b0;
         if (done_o || cyc > 200) break;
         if (poke && cyc == 2) begin start_i = 1'b1; op_i = 3'(OP_STORE); end
         else start_i = 1'b0;
         if (cp_req_o) begin
            if (cp_phase_o == 3'(PH_FIRST) || cp_phase_o == 3'(PH_BUSY)) begin
               if (busy_left > 0) begin
                  cp_reply_i = 2'(RP_BUSY); busy_left--;
               end else begin
                  cp_reply_i = cant ? 2'(RP_CANT) : 2'(RP_DONE);
               end
            end else if (cp_phase_o == 3'(PH_DATA)) begin
               if (op == 1) cp_rdata_i = rd_val;
               else begin
                  cp_rdata_i = pat(inst_id, k);
                  if (inc_left > 0) begin cp_reply_i = 2'(RP_INC); inc_left--; end
               end
            end
         end
         if (mem_req_o) begin
            macc++;
            if (mem_addr_o != addr + AW'(4*k)) aerr++;
            mem_rdata_i = mem[mem_addr_o[7:2]];
            mem_abort_i = (k == abort_k);
            #1;
            if (mem_we_o) begin
               if (mem_wdata_o != pat(inst_id, k)) derr++;
               mem[mem_addr_o[7:2]] = mem_wdata_o;
            end else if (cp_wdata_o != mem[mem_addr_o[7:2]]) derr++;
         end
         if (cp_req_o && cp_phase_o == 3'(PH_DATA) && op >= 3) k++;
         @(negedge clk);
      end
      start_i = 1'b0;
      got_code = int'(end_code_o); got_src = int'(intr_src_o);
      got_rdata = rdata_o; got_wait = wait_cycles_o;

      is_mem = (op == 3) || (op == 4);
      e_src = 0; e_macc = 0;
      if (nbusy > 0 && prio(lines) != 0) begin
         e_code = 4; e_cyc = 4; e_wait = 1; e_src = prio(lines);
      end else begin
         e_wait = (nbusy > 7) ? 7 : nbusy;
         if (cant) begin
            e_code = is_mem ? 2 : 1; e_cyc = 2 + 2*nbusy;
         end else if (is_mem) begin
            bad = (addr[AW-1:OKB] != '0) || (op == 4 && addr < AW'(VEC));
            words = ninc + 1;
            hit = !bad && abort_k >= 0 && abort_k <= ninc;
            e_macc = bad ? 0 : words;
            e_code = (bad || hit) ? 3 : 0;
            e_cyc = 3 + 2*nbusy + words;
         end else if (op == 1) begin
            e_code = 0; e_cyc = 4 + 2*nbusy;
         end else begin
            e_code = 0; e_cyc = 2 + 2*nbusy;
         end
      end
      chk(req, "end code", got_code, e_code);
      chk("R11", "cycles to done", cyc, e_cyc);
      chk("R3", "wait cycles", got_wait, e_wait);
      if (e_code == 4) chk("R4", "interrupt source", got_src, e_src);
      if (is_mem) begin
         chk("R7", "memory accesses", macc, e_macc);
         chk("R7", "address errors", aerr, 0);
         chk("R7", "data errors", derr, 0);
      end
      if (op == 1 && e_code == 0) chk("R10", "read data", got_rdata, rd_val);
      if (op == 1 && e_code == 1) chk("R5", "flags on failed read", got_rdata, {fl, 28'h0});
      @(negedge clk);
      chk("R11", "ready after done", longint'(ready_o), 1);
      if (poke) chk("R2", "no restart from busy-time start", longint'(cp_req_o), 0);
      {reset_req_i, fiq_i, fiq_dis_i, irq_i, irq_dis_i} = '0;
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      n_chk++; n_fail++;
      $display("FAIL R11 watchdog: actual %0d expected %0d", 150000, 0);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end

   initial begin
      void'($urandom(32'd4711));
      for (int i = 0; i < 64; i++) mem[i] = $urandom;
      repeat (3) @(negedge clk);
      chk("R1", "ready at reset", longint'(ready_o), 1);
      chk("R1", "cp_req at reset", longint'(cp_req_o), 0);
      chk("R1", "mem_req at reset", longint'(mem_req_o), 0);
      chk("R1", "done at reset", longint'(done_o), 0);
      rst_n = 1'b1;
      @(negedge clk);

      run_instr(0, 16'h0100, 0, 0, 0, -1, 5'b0, 0, "R2");
      run_instr(1, 16'h0100, 2, 0, 0, -1, 5'b0, 0, "R10");
      run_instr(1, 16'h0100, 1, 1, 0, -1, 5'b0, 0, "R5");
      run_instr(2, 16'h0100, 0, 1, 0, -1, 5'b0, 0, "R5");
      run_instr(3, 16'h0040, 0, 0, 3, -1, 5'b0, 0, "R7");
      run_instr(4, 16'h0080, 1, 0, 2, -1, 5'b0, 0, "R7");
      run_instr(4, 16'h0008, 0, 0, 1, -1, 5'b0, 0, "R8");
      run_instr(3, 16'h1040, 0, 0, 2, -1, 5'b0, 0, "R8");
      run_instr(3, 16'h0040, 2, 1, 2, -1, 5'b0, 0, "R6");
      run_instr(4, 16'h0060, 0, 1, 0, -1, 5'b0, 0, "R6");
      run_instr(3, 16'h0050, 0, 0, 3, 1, 5'b0, 0, "R9");
      run_instr(2, 16'h0000, 3, 0, 0, -1, 5'b00010, 0, "R4");
      run_instr(2, 16'h0000, 2, 0, 0, -1, 5'b11010, 0, "R4");
      run_instr(2, 16'h0000, 2, 0, 0, -1, 5'b01010, 0, "R4");
      run_instr(2, 16'h0000, 2, 0, 0, -1, 5'b01110, 0, "R4");
      run_instr(2, 16'h0000, 3, 0, 0, -1, 5'b01111, 0, "R4");
      run_instr(0, 16'h0000, 0, 0, 0, -1, 5'b11010, 0, "R4");
      run_instr(2, 16'h0000, 9, 0, 0, -1, 5'b0, 0, "R3");
      run_instr(3, 16'h0044, 3, 0, 1, -1, 5'b0, 1, "R2");

      for (int n = 0; n < 60; n++) begin
         int op = int'($urandom % 5);
         int nb = int'($urandom % 4);
         bit ct = ($urandom % 5) == 0;
         int ni = int'($urandom % 4);
         int ak = (($urandom % 5) == 0) ? int'($urandom % 4) : -1;
         logic [4:0] ln = (($urandom % 4) == 0) ? 5'($urandom) : 5'b0;
         logic [AW-1:0] ad = AW'(($urandom % 51) * 4);
         if (($urandom % 8) == 0) ad = ad | 16'h1000;
         run_instr(op, ad, nb, ct, ni, ak, ln, 0, "R11");
      end

      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
   end
endmodule